// File: doc/BRIEF.md
# Transmit Driver Activity Monitor

This block watches a line transmitter for signs of life. It takes one pulse-present indication for the positive driver output and one for the negative output. Each clock it counts how many cycles in a row have passed with no pulse on either output. When that run grows past a configurable limit (128 cycles by default), it reports a driver failure. The failure status stays set until a pulse is seen again.

Every rise or fall of the failure status sets a sticky change flag. An enable input gates that flag onto an active-low interrupt line. A one-cycle read strobe, issued when software reads the status register, clears the flag and so releases the interrupt. A status change that lands in the same cycle as a read is not lost.

Top module: `tx_drv_monitor`

## Requirements
- R1: With no pulse on either input for 128 consecutive sampled cycles, `drv_fail_o` stays low. On the 129th consecutive idle sample (more than 128), it goes high at that clock edge.
- R2: Once high, `drv_fail_o` stays high while the inputs stay idle. It returns low at the edge that samples a pulse.
- R3: A pulse on `pulse_pos_i` or on `pulse_neg_i` restarts the idle run from zero, so the 129-cycle count is measured from the last pulse of either polarity.
- R4: Every change of `drv_fail_o`, rising or falling, sets `chg_flag_o` at the same clock edge.
- R5: `irq_n_o` is low exactly when `chg_flag_o` is high and `irq_en_i` is high. Otherwise it is high.
- R6: A cycle with `stat_rd_i` high and no status change clears `chg_flag_o` at that edge, which returns `irq_n_o` high.
- R7: When a status change and `stat_rd_i` fall in the same cycle, `chg_flag_o` stays high after that edge and the interrupt remains asserted.
- R8: While reset (`rst_n` low) is applied, `drv_fail_o` and `chg_flag_o` are low, `irq_n_o` is high and the idle count is zero.
- R9: The change flag latches even while `irq_en_i` is low. Setting `irq_en_i` high afterwards asserts `irq_n_o` low with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_pos_i | input | 1 | Pulse seen on positive driver output this cycle |
| pulse_neg_i | input | 1 | Pulse seen on negative driver output this cycle |
| irq_en_i | input | 1 | Interrupt enable |
| stat_rd_i | input | 1 | One-cycle strobe: status register read |
| drv_fail_o | output | 1 | Driver failure status (1 = no activity) |
| chg_flag_o | output | 1 | Sticky status-change flag, cleared on read |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
Two events can fall in the same cycle: a status change and the status read that clears the flag. The bench holds a failure so the flag is set. It then drives a pulse and the read strobe together in one cycle, and expects the flag to remain set with the interrupt still low. After that it issues a lone read and expects the flag to clear. A behavioural model in the bench checks flag, status and interrupt after every edge.

// File: rtl/txmon_pkg.sv
package txmon_pkg;
   localparam int unsigned TXMON_DEF_IDLE = 128;

   function automatic int unsigned txmon_cnt_w(input int unsigned lim);
      return $clog2(lim + 1);
   endfunction
endpackage

// File: rtl/txmon_idle_timer.sv
module txmon_idle_timer
   import txmon_pkg::*;
#(
   parameter int unsigned IDLE_LIMIT = TXMON_DEF_IDLE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_i,
   output logic fail_o,
   output logic fail_nxt_o
);
   localparam int unsigned CW = txmon_cnt_w(IDLE_LIMIT);
   localparam logic [CW-1:0] LIM_C = CW'(IDLE_LIMIT);

   logic [CW-1:0] cnt_q, cnt_d;
   logic          fail_q, fail_d;

   if (IDLE_LIMIT < 1) begin : g_chk_limit
      $error("IDLE_LIMIT must be at least 1");
   end

   always_comb begin
      cnt_d  = cnt_q;
      fail_d = fail_q;
      if (act_i) begin
         cnt_d  = '0;
         fail_d = 1'b0;
      end else if (cnt_q == LIM_C) begin
         fail_d = 1'b1;
      end else begin
         cnt_d = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         fail_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         fail_q <= fail_d;
      end
   end

   assign fail_o     = fail_q;
   assign fail_nxt_o = fail_d;

   // R1: failure may only rise after an idle sample
   p_rise_needs_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail_q) |-> $past(!act_i));
   // R2: a sampled pulse clears the failure
   p_pulse_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      act_i |=> !fail_q);
   // R3: a sampled pulse restarts the idle run
   p_cnt_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      act_i |=> (cnt_q == '0));
   // R1: the idle count never exceeds its limit
   p_cnt_bounded_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIM_C);
endmodule

// File: rtl/txmon_event_latch.sv
module txmon_event_latch #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic en_i,
   output logic flag_o,
   output logic irq_n_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_i) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   if (IRQ_REG) begin : g_irq_reg
      logic irq_n_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_n_q <= 1'b1;
         else        irq_n_q <= ~(flag_q & en_i);
      end
      assign irq_n_o = irq_n_q;
   end else begin : g_irq_comb
      assign irq_n_o = ~(flag_q & en_i);
   end

   // R4: a status change sets the flag
   p_change_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q);
   // R6: a lone read clears the flag
   p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_q);
   // R7: a change coinciding with a read is kept
   p_change_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && set_i) |=> flag_q);
   // R4: the flag only rises on a change
   p_flag_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(set_i));
endmodule

// File: rtl/tx_drv_monitor.sv
module tx_drv_monitor
   import txmon_pkg::*;
#(
   parameter int unsigned IDLE_LIMIT = TXMON_DEF_IDLE,
   parameter bit          IRQ_REG    = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_pos_i,
   input  logic pulse_neg_i,
   input  logic irq_en_i,
   input  logic stat_rd_i,
   output logic drv_fail_o,
   output logic chg_flag_o,
   output logic irq_n_o
);
   logic act;
   logic fail_cur, fail_nxt;

   assign act = pulse_pos_i | pulse_neg_i;

   txmon_idle_timer #(.IDLE_LIMIT(IDLE_LIMIT)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_i      (act),
      .fail_o     (fail_cur),
      .fail_nxt_o (fail_nxt)
   );

   txmon_event_latch #(.IRQ_REG(IRQ_REG)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (fail_nxt ^ fail_cur),
      .clr_i   (stat_rd_i),
      .en_i    (irq_en_i),
      .flag_o  (chg_flag_o),
      .irq_n_o (irq_n_o)
   );

   assign drv_fail_o = fail_cur;

   // R4: every toggle of the status leaves the flag set
   p_toggle_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_fail_o != $past(drv_fail_o)) |-> chg_flag_o);
endmodule

// File: tb/tx_drv_monitor_tb.sv
module tx_drv_monitor_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pos = 1'b0, neg = 1'b0, en = 1'b1, rd = 1'b0;
   logic fail, flag, irq_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int m_idle = 0;
   bit m_fail = 1'b0;
   bit m_flag = 1'b0;

   always #5 clk = ~clk;

   tx_drv_monitor u_dut (
      .clk(clk), .rst_n(rst_n), .pulse_pos_i(pos), .pulse_neg_i(neg),
      .irq_en_i(en), .stat_rd_i(rd), .drv_fail_o(fail),
      .chg_flag_o(flag), .irq_n_o(irq_n)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference, compared 2 ns after every edge
   always @(posedge clk) begin
      bit nf;
      if (!rst_n) begin
         m_idle = 0; m_fail = 0; m_flag = 0;
      end else begin
         if (pos || neg) begin
            m_idle = 0; nf = 0;
         end else if (m_idle >= 128) begin
            nf = 1;
         end else begin
            m_idle++; nf = m_fail;
         end
         if (nf != m_fail) m_flag = 1;
         else if (rd) m_flag = 0;
         m_fail = nf;
      end
      #2;
      if (!done) begin
         chk("R1/R2 model status", fail, m_fail);
         chk("R4/R6 model flag", flag, m_flag);
         chk("R5 model irq", irq_n, !(m_flag && en));
      end
   end

   task automatic cyc(input logic p, input logic n, input logic r);
      pos = p; neg = n; rd = r;
      @(negedge clk);
   endtask

   task automatic idle(input int k);
      for (int i = 0; i < k; i++) cyc(0, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R8 reset status", fail, 1'b0);
      chk("R8 reset flag", flag, 1'b0);
      chk("R8 reset irq", irq_n, 1'b1);
      rst_n = 1'b1;
      for (int i = 0; i < 5; i++) cyc(1, 0, 0);
      idle(128);
      chk("R1 no fail at 128 idle", fail, 1'b0);
      idle(1);
      chk("R1 fail at 129 idle", fail, 1'b1);
      chk("R4 flag on rise", flag, 1'b1);
      chk("R5 irq low", irq_n, 1'b0);
      idle(10);
      chk("R2 fail held", fail, 1'b1);
      cyc(0, 0, 1);
      chk("R6 flag cleared", flag, 1'b0);
      chk("R6 irq released", irq_n, 1'b1);
      cyc(0, 1, 0);
      chk("R2 neg pulse clears fail", fail, 1'b0);
      chk("R4 flag on fall", flag, 1'b1);
      cyc(0, 0, 1);
      chk("R6 flag cleared again", flag, 1'b0);
      idle(100);
      cyc(0, 1, 0);
      idle(128);
      chk("R3 neg pulse restarted run", fail, 1'b0);
      cyc(1, 0, 0);
      idle(128);
      chk("R3 pos pulse restarted run", fail, 1'b0);
      idle(1);
      chk("R3 fail after full run", fail, 1'b1);
      cyc(1, 0, 1);
      chk("R7 fail cleared with read", fail, 1'b0);
      chk("R7 flag kept on coincident read", flag, 1'b1);
      chk("R7 irq still low", irq_n, 1'b0);
      cyc(0, 0, 1);
      chk("R7 later read clears", flag, 1'b0);
      en = 1'b0;
      idle(129);
      chk("R9 fail while disabled", fail, 1'b1);
      chk("R9 flag latched while disabled", flag, 1'b1);
      chk("R9 irq masked", irq_n, 1'b1);
      en = 1'b1;
      #1;
      chk("R9 irq on enable", irq_n, 1'b0);
      @(negedge clk);
      cyc(0, 0, 1);
      chk("R6 final clear", flag, 1'b0);
      idle(3);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule